// File: doc/BRIEF.md
# Auto-Acknowledging Multi-CPU Interrupt Controller

This block gathers a parameterised set of level-sensitive hardware interrupt lines and distributes them to a small group of CPUs. Every line has three controls: a mask bit, a software-trigger bit that is ORed with the line, and an affinity word that chooses which CPUs may take it. Every CPU also owns two inter-processor interrupts (IPIs). Any CPU may raise either of them, and the two behave the same way.

Each CPU has one event register. A read of it returns the most urgent source routed to that CPU and acknowledges that source in the same cycle. A hardware source is acknowledged by setting its mask bit. An IPI is acknowledged by clearing its pending flag. A read with nothing pending has no effect. Mask, trigger and IPI state change through separate set and clear addresses, so CPUs never need a read-modify-write.

The register bus is a single-cycle request with the issuing CPU number attached. Read data returns one cycle after the request. Addresses are 12 bits wide: bits [11:8] select a window and bits [7:0] select an offset within it. The window values are listed in the requirements.

Top module: `evt_intc`

## Requirements
- R1: Reset state. All mask bits are set, all software-trigger and IPI flags are clear, every affinity word is 1 (CPU0 only), every `irqOut` bit is low, and an event read returns 0.
- R2: A hardware line is pending only while it is high. A request that goes away before it is read leaves no trace. A read at global offset 0x04 returns the raw line levels.
- R3: Mask bits are changed by writing 1s to global offset 0x00 (set) or 0x01 (clear); zero bits in the write data leave their bits unchanged. A read of offset 0x00 returns the mask. A masked source is neither reported by an event read nor able to raise `irqOut`.
- R4: Global offset 0x80+i holds the affinity of line i. Bit c of that word lets CPU c receive the line, and several bits may be set at once.
- R5: The effective request of a line is the OR of the line and its software-trigger bit. That bit is set through global offset 0x02, cleared through 0x03, and read back at 0x02.
- R6: The event word has its type in bits [17:16] (0 none, 1 hardware, 2 IPI) and its index in bits [15:0]. IPI 0 wins over IPI 1, both IPIs win over any hardware line, and among hardware lines the lowest index wins.
- R7: When a hardware source is delivered by an event read, that source's mask bit is set in the same cycle. If the line is still high and software clears the mask bit again, the source is delivered again.
- R8: Within a CPU window, offset 0x01 sets IPI flags when written (bits 1:0) and returns them when read, and offset 0x02 clears them. Delivering an IPI clears its flag. One CPU can raise IPIs on another CPU through that CPU's explicit window.
- R9: An event read that returns type none leaves all mask and IPI state unchanged.
- R10: Window 0 holds the global registers. Window 1 maps to the CPU that issues the access. Window 2+k maps to CPU k no matter which CPU issues the access. Offset 0x00 of a CPU window is that CPU's event register.
- R11: `irqOut[c]` is a register. It is high while CPU c has an eligible IPI or hardware source, and it goes low on the clock after the last such source is acknowledged, masked or cleared.
- R12: Read data appears on `busRdata` together with a one-cycle `busRdValid` pulse, on the cycle after the read request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| irqLines | input | NUM_IRQ | Level-sensitive hardware interrupt lines |
| busValid | input | 1 | Bus request strobe, one cycle per access |
| busWrite | input | 1 | 1 for write, 0 for read |
| busCpu | input | CPU_W | Number of the CPU issuing the access |
| busAddr | input | 12 | Window in [11:8], offset in [7:0] |
| busWdata | input | 32 | Write data |
| busRdValid | output | 1 | Read data valid, one cycle after a read |
| busRdata | output | 32 | Read data |
| irqOut | output | NUM_CPU | Registered interrupt request, one bit per CPU |

## Verification
The bench makes a line and an IPI pending at the same time, and several lines pending at once. A wrong priority order shows up as an unexpected index in the event word. It reads the event register when nothing is pending, then reads the mask back. A design that acknowledges anyway would change the mask, or would lose the next delivery of a source that is still requesting. It reads one CPU's explicit window while another CPU issues the access. A decoder that always follows the issuing CPU would return or acknowledge the wrong source. It also samples `irqOut` just before and just after the last acknowledge. An output that is not registered, or that lags by an extra cycle, shows up at those two sample points.

// File: rtl/evt_intc_pkg.sv
package evt_intc_pkg;
  localparam int DATA_W = 32;
  localparam int ADDR_W = 12;

  typedef enum logic [2:0] {
    RD_NONE, RD_MASK, RD_SWTRIG, RD_RAW, RD_AFF, RD_EVT, RD_IPI
  } rdSel_e;

  typedef enum logic [1:0] {
    EV_NONE = 2'd0,
    EV_HW   = 2'd1,
    EV_IPI  = 2'd2
  } evType_e;

  // Strobes from the decoder to the state and arbitration datapath
  typedef struct packed {
    logic        maskSet;
    logic        maskClr;
    logic        swSet;
    logic        swClr;
    logic        affWr;
    logic        ipiSet;
    logic        ipiClr;
    logic        evtAck;
    rdSel_e      rdSel;
    logic [7:0]  cpu;
    logic [7:0]  idx;
    logic [31:0] wdata;
  } strobe_t;
endpackage

// File: rtl/evt_intc_ctrl.sv
module evt_intc_ctrl
  import evt_intc_pkg::*;
#(
  parameter int NUM_IRQ = 16,
  parameter int NUM_CPU = 2,
  parameter int CPU_W   = 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              busValid,
  input  logic              busWrite,
  input  logic [CPU_W-1:0]  busCpu,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic [DATA_W-1:0] busWdata,
  output strobe_t           stb
);
  localparam int WIN_W = ADDR_W - 8;

  logic [WIN_W-1:0] win;
  logic [7:0]       off;
  logic [7:0]       tgt;
  logic             cpuOk;
  logic             affOk;

  always_comb begin
    win = busAddr[ADDR_W-1:8];
    off = busAddr[7:0];
    affOk = off[7] && (32'(off[6:0]) < NUM_IRQ);
    if (win == WIN_W'(1)) begin
      tgt   = 8'(busCpu);
      cpuOk = 32'(busCpu) < NUM_CPU;
    end else begin
      tgt   = 8'(win) - 8'd2;
      cpuOk = (32'(win) >= 2) && ((32'(win) - 2) < NUM_CPU);
    end

    stb       = '0;
    stb.rdSel = RD_NONE;
    stb.wdata = busWdata;
    if (busValid) begin
      if (win == '0) begin
        if (busWrite) begin
          case (off)
            8'h00:   stb.maskSet = 1'b1;
            8'h01:   stb.maskClr = 1'b1;
            8'h02:   stb.swSet   = 1'b1;
            8'h03:   stb.swClr   = 1'b1;
            default: if (affOk) begin
              stb.affWr = 1'b1;
              stb.idx   = {1'b0, off[6:0]};
            end
          endcase
        end else begin
          case (off)
            8'h00:   stb.rdSel = RD_MASK;
            8'h02:   stb.rdSel = RD_SWTRIG;
            8'h04:   stb.rdSel = RD_RAW;
            default: if (affOk) begin
              stb.rdSel = RD_AFF;
              stb.idx   = {1'b0, off[6:0]};
            end
          endcase
        end
      end else if (cpuOk) begin
        stb.cpu = tgt;
        if (busWrite) begin
          if (off == 8'h01) stb.ipiSet = 1'b1;
          if (off == 8'h02) stb.ipiClr = 1'b1;
        end else begin
          if (off == 8'h00) begin
            stb.evtAck = 1'b1;
            stb.rdSel  = RD_EVT;
          end
          if (off == 8'h01) stb.rdSel = RD_IPI;
        end
      end
    end
  end

  AST_ONE_STROBE: assert property (@(posedge clk) disable iff (rst)
    $onehot0({stb.maskSet, stb.maskClr, stb.swSet, stb.swClr,
              stb.affWr, stb.ipiSet, stb.ipiClr, stb.evtAck})); // R10
endmodule

// File: rtl/evt_intc_dp.sv
module evt_intc_dp
  import evt_intc_pkg::*;
#(
  parameter int NUM_IRQ = 16,
  parameter int NUM_CPU = 2
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [NUM_IRQ-1:0] irqLines,
  input  strobe_t            stb,
  output logic               rdValid,
  output logic [DATA_W-1:0]  rdData,
  output logic [NUM_CPU-1:0] irqOut
);
  logic [NUM_IRQ-1:0]              maskQ, swQ, live, autoMask;
  logic [NUM_IRQ-1:0][NUM_CPU-1:0] affQ;
  logic [NUM_CPU-1:0][1:0]         ipiQ;
  logic [NUM_CPU-1:0][1:0]         evType;
  logic [NUM_CPU-1:0][15:0]        evIdx;
  logic [NUM_CPU-1:0]              pend;
  logic [NUM_CPU-1:0][NUM_IRQ-1:0] ackHwVec;
  logic [NUM_CPU-1:0][1:0]         ackIpiVec;
  logic [NUM_IRQ-1:0]              wMask;
  logic [DATA_W-1:0]               rdNext;
  logic                            unusedBits;

  assign live       = (irqLines | swQ) & ~maskQ;
  assign wMask      = stb.wdata[NUM_IRQ-1:0];
  assign unusedBits = ^stb.wdata;

  for (genvar c = 0; c < NUM_CPU; c++) begin : g_cpu
    logic [NUM_IRQ-1:0] elig;
    logic [15:0]        hwIdx;
    logic [1:0]         typeL;
    logic [15:0]        idxL;
    logic               ackThis;

    always_comb begin
      for (int i = 0; i < NUM_IRQ; i++) elig[i] = live[i] & affQ[i][c];
      hwIdx = '0;
      for (int i = NUM_IRQ - 1; i >= 0; i--) if (elig[i]) hwIdx = 16'(i);
      if (ipiQ[c][0])      begin typeL = EV_IPI;  idxL = 16'd0; end
      else if (ipiQ[c][1]) begin typeL = EV_IPI;  idxL = 16'd1; end
      else if (|elig)      begin typeL = EV_HW;   idxL = hwIdx; end
      else                 begin typeL = EV_NONE; idxL = 16'd0; end
    end

    assign ackThis      = stb.evtAck && (stb.cpu == 8'(c));
    assign evType[c]    = typeL;
    assign evIdx[c]     = idxL;
    assign pend[c]      = (|ipiQ[c]) | (|elig);
    assign ackHwVec[c]  = (ackThis && typeL == EV_HW) ? (NUM_IRQ'(1) << hwIdx) : '0;
    assign ackIpiVec[c] = (ackThis && typeL == EV_IPI) ? (2'b01 << idxL[0]) : 2'b00;

    AST_AUTO_MASK: assert property (@(posedge clk) disable iff (rst)
      (ackThis && typeL == EV_HW) |=> maskQ[$past(hwIdx)]); // R7
    AST_IPI_DROP: assert property (@(posedge clk) disable iff (rst)
      (ackThis && typeL == EV_IPI) |=> !ipiQ[c][$past(idxL[0])]); // R8
    AST_NONE_QUIET: assert property (@(posedge clk) disable iff (rst)
      (ackThis && typeL == EV_NONE) |=> ($stable(maskQ) && $stable(ipiQ))); // R9
    AST_OUT_IDLE: assert property (@(posedge clk) disable iff (rst)
      ($past(maskQ) == '1 && $past(ipiQ[c]) == 2'b00) |-> !irqOut[c]); // R3
  end

  always_comb begin
    autoMask = '0;
    for (int c = 0; c < NUM_CPU; c++) autoMask |= ackHwVec[c];
  end

  always_comb begin
    rdNext = '0;
    case (stb.rdSel)
      RD_MASK:   rdNext = DATA_W'(maskQ);
      RD_SWTRIG: rdNext = DATA_W'(swQ);
      RD_RAW:    rdNext = DATA_W'(irqLines);
      RD_AFF:
        for (int i = 0; i < NUM_IRQ; i++)
          if (stb.idx == 8'(i)) rdNext = DATA_W'(affQ[i]);
      RD_EVT:
        for (int c = 0; c < NUM_CPU; c++)
          if (stb.cpu == 8'(c)) rdNext = {14'd0, evType[c], evIdx[c]};
      RD_IPI:
        for (int c = 0; c < NUM_CPU; c++)
          if (stb.cpu == 8'(c)) rdNext = DATA_W'(ipiQ[c]);
      default: rdNext = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      maskQ   <= '1;
      swQ     <= '0;
      ipiQ    <= '0;
      irqOut  <= '0;
      rdValid <= 1'b0;
      rdData  <= '0;
      for (int i = 0; i < NUM_IRQ; i++) affQ[i] <= NUM_CPU'(1);
    end else begin
      maskQ <= (maskQ | (stb.maskSet ? wMask : '0) | autoMask)
             & ~(stb.maskClr ? wMask : '0);
      swQ   <= (swQ | (stb.swSet ? wMask : '0)) & ~(stb.swClr ? wMask : '0);
      for (int i = 0; i < NUM_IRQ; i++)
        if (stb.affWr && stb.idx == 8'(i)) affQ[i] <= stb.wdata[NUM_CPU-1:0];
      for (int c = 0; c < NUM_CPU; c++) begin
        if (stb.cpu == 8'(c) && stb.ipiSet)
          ipiQ[c] <= ipiQ[c] | stb.wdata[1:0];
        else if (stb.cpu == 8'(c) && stb.ipiClr)
          ipiQ[c] <= ipiQ[c] & ~stb.wdata[1:0];
        else
          ipiQ[c] <= ipiQ[c] & ~ackIpiVec[c];
      end
      irqOut  <= pend;
      rdValid <= (stb.rdSel != RD_NONE);
      rdData  <= rdNext;
    end
  end
endmodule

// File: rtl/evt_intc.sv
module evt_intc
  import evt_intc_pkg::*;
#(
  parameter int NUM_IRQ = 16,
  parameter int NUM_CPU = 2,
  localparam int CPU_W  = (NUM_CPU > 1) ? $clog2(NUM_CPU) : 1
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [NUM_IRQ-1:0] irqLines,
  input  logic               busValid,
  input  logic               busWrite,
  input  logic [CPU_W-1:0]   busCpu,
  input  logic [11:0]        busAddr,
  input  logic [31:0]        busWdata,
  output logic               busRdValid,
  output logic [31:0]        busRdata,
  output logic [NUM_CPU-1:0] irqOut
);
  strobe_t stb;

  initial begin
    assert (NUM_IRQ >= 1 && NUM_IRQ <= 32);
    assert (NUM_CPU >= 1 && NUM_CPU <= 8);
  end

  evt_intc_ctrl #(.NUM_IRQ(NUM_IRQ), .NUM_CPU(NUM_CPU), .CPU_W(CPU_W)) u_ctrl (
    .clk(clk), .rst(rst), .busValid(busValid), .busWrite(busWrite),
    .busCpu(busCpu), .busAddr(busAddr), .busWdata(busWdata), .stb(stb)
  );

  evt_intc_dp #(.NUM_IRQ(NUM_IRQ), .NUM_CPU(NUM_CPU)) u_dp (
    .clk(clk), .rst(rst), .irqLines(irqLines), .stb(stb),
    .rdValid(busRdValid), .rdData(busRdata), .irqOut(irqOut)
  );
endmodule

// File: tb/evt_intc_test.sv
module evt_intc_test;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [15:0] irqLines = '0;
  logic        busValid = 1'b0;
  logic        busWrite = 1'b0;
  logic [0:0]  busCpu = '0;
  logic [11:0] busAddr = '0;
  logic [31:0] busWdata = '0;
  logic        busRdValid;
  logic [31:0] busRdata;
  logic [1:0]  irqOut;

  int checks = 0;
  int fails  = 0;

  always #5 clk = ~clk;

  evt_intc #(.NUM_IRQ(16), .NUM_CPU(2)) uut (
    .clk(clk), .rst(rst), .irqLines(irqLines), .busValid(busValid),
    .busWrite(busWrite), .busCpu(busCpu), .busAddr(busAddr),
    .busWdata(busWdata), .busRdValid(busRdValid), .busRdata(busRdata),
    .irqOut(irqOut)
  );

  function automatic logic [31:0] hwEv(input int n);
    return 32'h10000 | 32'(n);
  endfunction

  function automatic logic [31:0] ipiEv(input int n);
    return 32'h20000 | 32'(n);
  endfunction

  task automatic check(input string req, input logic [31:0] got, input logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s: got %h expected %h", req, got, exp);
    end
  endtask

  task automatic doReset();
    irqLines = '0;
    busValid = 1'b0;
    rst = 1'b1;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
  endtask

  task automatic busWr(input logic cpu, input logic [11:0] addr, input logic [31:0] data);
    @(negedge clk);
    busValid = 1'b1; busWrite = 1'b1; busCpu = cpu; busAddr = addr; busWdata = data;
    @(negedge clk);
    busValid = 1'b0; busWrite = 1'b0;
  endtask

  task automatic busRd(input logic cpu, input logic [11:0] addr, output logic [31:0] data);
    @(negedge clk);
    busValid = 1'b1; busWrite = 1'b0; busCpu = cpu; busAddr = addr;
    @(negedge clk);
    busValid = 1'b0;
    check("R12 rdValid", 32'(busRdValid), 32'd1);
    data = busRdata;
  endtask

  task automatic testReset();
    logic [31:0] d;
    doReset();
    check("R1 irqOut", 32'(irqOut), 32'd0);
    busRd(0, 12'h000, d); check("R1 mask", d, 32'h0000FFFF);
    busRd(0, 12'h002, d); check("R1 swtrig", d, 32'd0);
    busRd(0, 12'h085, d); check("R1 affinity", d, 32'd1);
    busRd(0, 12'h100, d); check("R1 event", d, 32'd0);
    busRd(1, 12'h201, d); check("R1 ipi", d, 32'd0);
  endtask

  task automatic testLevel();
    logic [31:0] d;
    doReset();
    irqLines[5] = 1'b1;
    busWr(0, 12'h001, 32'h20);
    @(negedge clk); check("R2 level raise", 32'(irqOut), 32'd1);
    busRd(0, 12'h004, d); check("R2 raw lines", d, 32'h20);
    irqLines[5] = 1'b0;
    @(negedge clk); check("R2 level drop", 32'(irqOut), 32'd0);
    busRd(0, 12'h100, d); check("R2 no latch", d, 32'd0);
  endtask

  task automatic testMask();
    logic [31:0] d;
    doReset();
    irqLines[5] = 1'b1; irqLines[6] = 1'b1;
    busWr(0, 12'h001, 32'h60);
    @(negedge clk); check("R3 unmasked raise", 32'(irqOut), 32'd1);
    busWr(0, 12'h000, 32'h20);
    busRd(0, 12'h000, d); check("R3 w1s keeps others", d, 32'h0000FFBF);
    busRd(0, 12'h100, d); check("R3 masked skipped", d, hwEv(6));
    @(negedge clk); check("R3 all masked", 32'(irqOut), 32'd0);
    busRd(0, 12'h100, d); check("R3 masked not reported", d, 32'd0);
  endtask

  task automatic testPriority();
    logic [31:0] d;
    doReset();
    irqLines[3] = 1'b1; irqLines[9] = 1'b1;
    busWr(0, 12'h001, 32'h208);
    @(negedge clk);
    busRd(0, 12'h100, d); check("R6 lowest first", d, hwEv(3));
    busRd(0, 12'h000, d); check("R7 auto mask", d, 32'h0000FDFF);
    busRd(0, 12'h100, d); check("R6 next source", d, hwEv(9));
    check("R11 held at ack", 32'(irqOut), 32'd1);
    @(negedge clk); check("R11 drop after ack", 32'(irqOut), 32'd0);
    busRd(0, 12'h100, d); check("R9 none", d, 32'd0);
    busRd(0, 12'h000, d); check("R9 mask unchanged", d, 32'h0000FFFF);
    busWr(0, 12'h001, 32'h008);
    @(negedge clk); check("R7 redeliver raise", 32'(irqOut), 32'd1);
    busRd(0, 12'h100, d); check("R7 redeliver", d, hwEv(3));
  endtask

  task automatic testAffinity();
    logic [31:0] d;
    doReset();
    irqLines[9] = 1'b1; irqLines[4] = 1'b1;
    busWr(0, 12'h089, 32'd2);
    busWr(0, 12'h084, 32'd3);
    busWr(0, 12'h001, 32'h210);
    @(negedge clk); check("R4 both cpus", 32'(irqOut), 32'd3);
    busRd(0, 12'h300, d); check("R10 explicit window", d, hwEv(4));
    @(negedge clk); check("R4 cpu1 only", 32'(irqOut), 32'd2);
    busRd(1, 12'h100, d); check("R10 self window cpu1", d, hwEv(9));
    busRd(0, 12'h089, d); check("R4 affinity readback", d, 32'd2);
  endtask

  task automatic testSoftware();
    logic [31:0] d;
    doReset();
    busWr(0, 12'h001, 32'h80);
    @(negedge clk); check("R5 idle", 32'(irqOut), 32'd0);
    busWr(0, 12'h002, 32'h80);
    @(negedge clk); check("R5 sw raise", 32'(irqOut), 32'd1);
    busRd(0, 12'h002, d); check("R5 sw readback", d, 32'h80);
    busRd(0, 12'h100, d); check("R5 sw event", d, hwEv(7));
    busWr(0, 12'h003, 32'h80);
    busRd(0, 12'h002, d); check("R5 sw clear", d, 32'd0);
    busWr(0, 12'h001, 32'h80);
    @(negedge clk); check("R5 no request", 32'(irqOut), 32'd0);
  endtask

  task automatic testIpi();
    logic [31:0] d;
    doReset();
    irqLines[2] = 1'b1;
    busWr(0, 12'h001, 32'h4);
    busWr(1, 12'h201, 32'd2);
    busRd(0, 12'h201, d); check("R8 remote raise", d, 32'd2);
    busRd(0, 12'h100, d); check("R6 ipi over hw", d, ipiEv(1));
    busRd(0, 12'h201, d); check("R8 delivery clears", d, 32'd0);
    busWr(0, 12'h101, 32'd3);
    busRd(0, 12'h100, d); check("R6 ipi0 first", d, ipiEv(0));
    busRd(0, 12'h100, d); check("R6 ipi1 second", d, ipiEv(1));
    busRd(0, 12'h100, d); check("R6 hw after ipis", d, hwEv(2));
    busWr(0, 12'h301, 32'd1);
    @(negedge clk); check("R8 cpu1 raise", 32'(irqOut), 32'd2);
    busWr(0, 12'h302, 32'd1);
    @(negedge clk); check("R8 clear", 32'(irqOut), 32'd0);
    busRd(1, 12'h100, d); check("R8 cleared none", d, 32'd0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    testReset();
    testLevel();
    testMask();
    testPriority();
    testAffinity();
    testSoftware();
    testIpi();
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule